// File: doc/BRIEF.md
# Inter-processor doorbell mailbox

This block is a register-mapped doorbell between a host CPU and a peer processor. The host rings the peer on a numbered channel in two steps. First it sets that channel's busy flag. Then it writes the channel number, and that write launches a one-cycle doorbell pulse toward the peer. The flag stays set until the peer reports that it has taken the event, so the host can poll busy to see whether an earlier ring is still outstanding. In the other direction, the peer raises events on up to eight channels. These collect as pending bits, which the host reads, gates with an enable mask and clears by writing ones to a separate acknowledge register. A single active-high level interrupt follows the enabled pending bits.

By convention, channel 0 carries host commands, channel 1 carries peer responses and channel 7 carries peer exceptions. The enable mask therefore comes out of reset with channels 1 and 7 enabled (0x82). Sixteen 32-bit general words are reachable from both sides: two groups of scratch words and two groups of shadow words. The two processors use them to trade ring base addresses, sizes and indices.

Top module: `mbox_doorbell`

## Requirements
- R1: After reset, every register reads 0, except the enable mask at byte offset 0x018, which reads 0x82. The interrupt is low.
- R2: A host write to the busy register (0x004) sets each busy bit written as 1 and leaves bits written as 0 unchanged. The register reads back its current bits.
- R3: A host write of value N to the send register (0x00C) with N below the channel count drives bell_valid high for exactly the next cycle, with bell_ch = N. A value of 8 or more sends nothing. The register reads back the low 8 bits of the last value written.
- R4: A peer take on channel C clears busy bit C. If the host sets the same bit in the same cycle, the bit stays set.
- R5: peer_evt bit k sets pending bit k. The pending register (0x010) shows the pending bits in bits 7:0 and zeros above them.
- R6: A host write to the acknowledge register (0x014) clears each pending bit written as 1 and leaves the others unchanged. The acknowledge register reads 0.
- R7: If a peer event and a host acknowledge hit the same pending bit in the same cycle, the bit stays pending.
- R8: irq is high exactly while some pending bit is enabled in the mask at 0x018. A mask of 0 holds irq low.
- R9: The scratch and shadow words at 0x020–0x03C and 0x050–0x06C are 32-bit read/write storage. Each side reads what either side last wrote. When both sides write the same word in one cycle, the host value is kept.
- R10: The start register (0x008) and the second mask (0x01C) are plain 8-bit read/write storage. Any other offset reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 8 | Host byte address (word aligned) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |
| irq | output | 1 | Level interrupt to the host |
| peer_evt | input | 8 | One-cycle event set bits from the peer |
| peer_take | input | 1 | Peer has taken a doorbell |
| peer_take_ch | input | 3 | Channel that was taken |
| bell_valid | output | 1 | Doorbell pulse to the peer |
| bell_ch | output | 3 | Channel of the doorbell |
| peer_we | input | 1 | Peer write strobe for shared words |
| peer_addr | input | 8 | Peer byte address of a shared word |
| peer_wdata | input | 32 | Peer write data |
| peer_rdata | output | 32 | Peer read data for peer_addr |

## Verification
The bench goes after the collisions on the same bit or word in the same cycle. If an acknowledge beat a peer event, the event would be lost silently. If a take beat a fresh busy set, the host would see a false "done". If the peer beat the host on a shared word, the host's index would be overwritten. The bench also sends out-of-range channel numbers such as 9 and 0x100. A design that decoded only the low bits would ring a channel that nobody asked for. It probes the holes in the map (0x000, 0x040, 0x070) and checks that nothing aliases into the shared words. Finally, it sets the mask to 0 while events are pending, which must drop irq without losing the pending bits.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

   localparam int STORE_WORDS = 16;
   localparam int STORE_IW    = $clog2(STORE_WORDS);

   typedef enum logic [3:0] {
      SEL_NONE, SEL_BUSY, SEL_START, SEL_SEND, SEL_PEND,
      SEL_ACK, SEL_EN0, SEL_EN1, SEL_STORE
   } sel_e;

   function automatic logic store_hit(input logic [5:0] w);
      return ((w >= 6'd8) && (w <= 6'd15)) || ((w >= 6'd20) && (w <= 6'd27));
   endfunction

   function automatic logic [STORE_IW-1:0] store_slot(input logic [5:0] w);
      logic [5:0] s;
      s = (w <= 6'd15) ? (w - 6'd8) : (w - 6'd12);
      return s[STORE_IW-1:0];
   endfunction

   function automatic sel_e decode(input logic [5:0] w);
      sel_e r;
      case (w)
         6'd1:    r = SEL_BUSY;
         6'd2:    r = SEL_START;
         6'd3:    r = SEL_SEND;
         6'd4:    r = SEL_PEND;
         6'd5:    r = SEL_ACK;
         6'd6:    r = SEL_EN0;
         6'd7:    r = SEL_EN1;
         default: r = store_hit(w) ? SEL_STORE : SEL_NONE;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/mbox_pending.sv
module mbox_pending #(
   parameter int          NCH     = 8,
   parameter logic [7:0]  EN_RST  = 8'h82,
   parameter bit          REG_IRQ = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] evt,
   input  logic           ack_we,
   input  logic [NCH-1:0] ack_bits,
   input  logic           en_we,
   input  logic [NCH-1:0] en_d,
   output logic [NCH-1:0] pend,
   output logic [NCH-1:0] en,
   output logic           irq
);
   logic [NCH-1:0] clr;
   logic           irq_now;

   assign clr     = ack_we ? ack_bits : '0;
   assign irq_now = |(pend & en);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= '0;
         en   <= EN_RST[NCH-1:0];
      end else begin
         pend <= (pend & ~clr) | evt;
         if (en_we) en <= en_d;
      end
   end

   generate
      if (REG_IRQ) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_now;
         end
         assign irq = irq_q;
         assert_mask_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $past(en == '0) |-> !irq);
      end else begin : g_irq_comb
         assign irq = irq_now;
         assert_mask_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (en == '0) |-> !irq);
      end
   endgenerate

   assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_we && ack_bits[0] && !evt[0]) |=> !pend[0]);
   assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[NCH-1] && ack_we && ack_bits[NCH-1]) |=> pend[NCH-1]);
   assert_event_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      evt[1] |=> pend[1]);
endmodule

// File: rtl/mbox_send.sv
module mbox_send #(
   parameter int NCH    = 8,
   parameter int DATA_W = 32,
   localparam int CH_W  = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_we,
   input  logic [NCH-1:0]    busy_d,
   input  logic              send_we,
   input  logic [DATA_W-1:0] send_d,
   input  logic              take,
   input  logic [CH_W-1:0]   take_ch,
   output logic [NCH-1:0]    busy,
   output logic [7:0]        send_q,
   output logic              bell_valid,
   output logic [CH_W-1:0]   bell_ch
);
   logic [NCH-1:0] set_bits, clr_bits;
   logic           in_range;

   assign set_bits = busy_we ? busy_d : '0;
   assign clr_bits = take ? (NCH'(1) << take_ch) : '0;
   assign in_range = send_d < DATA_W'(NCH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy       <= '0;
         send_q     <= '0;
         bell_valid <= 1'b0;
         bell_ch    <= '0;
      end else begin
         busy       <= (busy & ~clr_bits) | set_bits;
         bell_valid <= send_we && in_range;
         if (send_we) begin
            send_q <= send_d[7:0];
            if (in_range) bell_ch <= send_d[CH_W-1:0];
         end
      end
   end

   assert_bell_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (send_we && in_range) |=> (bell_valid && bell_ch == $past(send_d[CH_W-1:0])));
   assert_no_bell_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !send_we |=> !bell_valid);
   assert_take_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !(busy_we && busy_d[take_ch])) |=> !busy[$past(take_ch)]);
   assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_we && busy_d[0]) |=> busy[0]);
endmodule

// File: rtl/mbox_store.sv
module mbox_store #(
   parameter int DATA_W = 32,
   parameter int NW     = 16,
   localparam int IW    = $clog2(NW)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     h_we,
   input  logic [IW-1:0]            h_slot,
   input  logic [DATA_W-1:0]        h_wd,
   input  logic                     p_we,
   input  logic [IW-1:0]            p_slot,
   input  logic [DATA_W-1:0]        p_wd,
   output logic [NW-1:0][DATA_W-1:0] words
);
   genvar i;
   generate
      for (i = 0; i < NW; i++) begin : g_word
         always_ff @(posedge clk) begin
            if (!rst_n)                               words[i] <= '0;
            else if (h_we && h_slot == IW'(i))        words[i] <= h_wd;
            else if (p_we && p_slot == IW'(i))        words[i] <= p_wd;
         end
      end
   endgenerate

   assert_host_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (h_we && p_we && h_slot == p_slot) |=> words[$past(h_slot)] == $past(h_wd));
   assert_peer_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (p_we && !(h_we && h_slot == p_slot)) |=> words[$past(p_slot)] == $past(p_wd));
endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell
   import mbox_pkg::*;
#(
   parameter int         NCH     = 8,
   parameter int         DATA_W  = 32,
   parameter int         ADDR_W  = 8,
   parameter logic [7:0] EN_RST  = 8'h82,
   parameter bit         REG_IRQ = 1'b0,
   localparam int        CH_W    = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              irq,
   input  logic [NCH-1:0]    peer_evt,
   input  logic              peer_take,
   input  logic [CH_W-1:0]   peer_take_ch,
   output logic              bell_valid,
   output logic [CH_W-1:0]   bell_ch,
   input  logic              peer_we,
   input  logic [ADDR_W-1:0] peer_addr,
   input  logic [DATA_W-1:0] peer_wdata,
   output logic [DATA_W-1:0] peer_rdata
);
   localparam int WI = ADDR_W - 2;

   initial begin
      assert (NCH >= 2 && NCH <= 8) else $error("NCH must be 2..8");
      assert (DATA_W >= 8)          else $error("DATA_W must be at least 8");
      assert (ADDR_W >= 8)          else $error("ADDR_W must be at least 8");
   end

   logic [WI-1:0] h_word, p_word;
   logic          h_ok, p_ok;
   sel_e          h_sel, p_sel;
   logic [STORE_IW-1:0] h_slot, p_slot;

   assign h_word = host_addr[ADDR_W-1:2];
   assign p_word = peer_addr[ADDR_W-1:2];
   assign h_ok   = (h_word >> 6) == '0;
   assign p_ok   = (p_word >> 6) == '0;
   assign h_sel  = h_ok ? decode(h_word[5:0]) : SEL_NONE;
   assign p_sel  = (p_ok && store_hit(p_word[5:0])) ? SEL_STORE : SEL_NONE;
   assign h_slot = store_slot(h_word[5:0]);
   assign p_slot = store_slot(p_word[5:0]);

   logic [NCH-1:0] pend, en0, busy;
   logic [7:0]     send_q, start_q, en1_q;
   logic [STORE_WORDS-1:0][DATA_W-1:0] words;

   mbox_pending #(.NCH(NCH), .EN_RST(EN_RST), .REG_IRQ(REG_IRQ)) u_pend (
      .clk(clk), .rst_n(rst_n), .evt(peer_evt),
      .ack_we(host_we && h_sel == SEL_ACK), .ack_bits(host_wdata[NCH-1:0]),
      .en_we(host_we && h_sel == SEL_EN0), .en_d(host_wdata[NCH-1:0]),
      .pend(pend), .en(en0), .irq(irq));

   mbox_send #(.NCH(NCH), .DATA_W(DATA_W)) u_send (
      .clk(clk), .rst_n(rst_n),
      .busy_we(host_we && h_sel == SEL_BUSY), .busy_d(host_wdata[NCH-1:0]),
      .send_we(host_we && h_sel == SEL_SEND), .send_d(host_wdata),
      .take(peer_take), .take_ch(peer_take_ch),
      .busy(busy), .send_q(send_q), .bell_valid(bell_valid), .bell_ch(bell_ch));

   mbox_store #(.DATA_W(DATA_W), .NW(STORE_WORDS)) u_store (
      .clk(clk), .rst_n(rst_n),
      .h_we(host_we && h_sel == SEL_STORE), .h_slot(h_slot), .h_wd(host_wdata),
      .p_we(peer_we && p_sel == SEL_STORE), .p_slot(p_slot), .p_wd(peer_wdata),
      .words(words));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         en1_q   <= '0;
      end else if (host_we) begin
         if (h_sel == SEL_START) start_q <= host_wdata[7:0];
         if (h_sel == SEL_EN1)   en1_q   <= host_wdata[7:0];
      end
   end

   always_comb begin
      host_rdata = '0;
      case (h_sel)
         SEL_BUSY:  host_rdata[NCH-1:0] = busy;
         SEL_START: host_rdata[7:0]     = start_q;
         SEL_SEND:  host_rdata[7:0]     = send_q;
         SEL_PEND:  host_rdata[NCH-1:0] = pend;
         SEL_EN0:   host_rdata[NCH-1:0] = en0;
         SEL_EN1:   host_rdata[7:0]     = en1_q;
         SEL_STORE: host_rdata          = words[h_slot];
         default:   host_rdata          = '0;
      endcase
   end

   assign peer_rdata = (p_sel == SEL_STORE) ? words[p_slot] : '0;

   assert_hole_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (h_sel == SEL_NONE || h_sel == SEL_ACK) |-> host_rdata == '0);
   assert_pend_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (h_sel == SEL_PEND) |-> (host_rdata >> NCH) == '0);
endmodule

// File: tb/mbox_doorbell_test.sv
module mbox_doorbell_test;
   logic        clk = 0, rst_n = 0;
   logic        host_we = 0, peer_take = 0, peer_we = 0;
   logic [7:0]  host_addr = 0, peer_addr = 0, peer_evt = 0;
   logic [31:0] host_wdata = 0, peer_wdata = 0;
   logic [2:0]  peer_take_ch = 0;
   logic [31:0] host_rdata, peer_rdata;
   logic        irq, bell_valid;
   logic [2:0]  bell_ch;

   always #2.5 clk = ~clk;

   mbox_doorbell uut (.*);

   int checks = 0, errors = 0;
   logic [7:0]  m_busy, m_start, m_send, m_pend, m_en0, m_en1;
   logic [31:0] m_st [16];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int slot_of(input logic [7:0] a);
      int w = a >> 2;
      if (w >= 8 && w <= 15)  return w - 8;
      if (w >= 20 && w <= 27) return w - 12;
      return -1;
   endfunction

   function automatic logic [31:0] exp_rd(input logic [7:0] a);
      if (a[1:0] != 0 && slot_of(a) < 0) return 0;
      case (a >> 2)
         1: return {24'd0, m_busy};
         2: return {24'd0, m_start};
         3: return {24'd0, m_send};
         4: return {24'd0, m_pend};
         6: return {24'd0, m_en0};
         7: return {24'd0, m_en1};
         default: return (slot_of(a) >= 0) ? m_st[slot_of(a)] : 32'd0;
      endcase
   endfunction

   task automatic model_reset();
      m_busy = 0; m_start = 0; m_send = 0; m_pend = 0; m_en0 = 8'h82; m_en1 = 0;
      for (int i = 0; i < 16; i++) m_st[i] = 0;
   endtask

   task automatic cyc(input logic hwe, input logic [7:0] ha, input logic [31:0] hd,
                      input logic [7:0] ev, input logic tk, input logic [2:0] tc,
                      input logic pwe, input logic [7:0] pa, input logic [31:0] pd);
      logic bell_e;
      @(negedge clk);
      host_we = hwe; host_addr = ha; host_wdata = hd; peer_evt = ev;
      peer_take = tk; peer_take_ch = tc; peer_we = pwe; peer_addr = pa; peer_wdata = pd;
      @(posedge clk);
      #1;
      bell_e = hwe && (ha >> 2) == 3 && hd < 8;
      if (tk) m_busy[tc] = 1'b0;
      m_pend = m_pend | ev;
      if (pwe && slot_of(pa) >= 0) m_st[slot_of(pa)] = pd;
      if (hwe) case (ha >> 2)
         1: m_busy  = m_busy | hd[7:0];
         2: m_start = hd[7:0];
         3: m_send  = hd[7:0];
         5: m_pend  = (m_pend & ~hd[7:0]) | ev;
         6: m_en0   = hd[7:0];
         7: m_en1   = hd[7:0];
         default: if (slot_of(ha) >= 0) m_st[slot_of(ha)] = hd;
      endcase
      chk("R3 bell_valid", {31'd0, bell_valid}, {31'd0, bell_e});
      if (bell_e) chk("R3 bell_ch", {29'd0, bell_ch}, {29'd0, hd[2:0]});
      host_we = 0; peer_we = 0; peer_take = 0; peer_evt = 0;
   endtask

   task automatic idle();
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic rd(input string tag, input logic [7:0] a);
      @(negedge clk);
      host_we = 0; host_addr = a;
      #1 chk(tag, host_rdata, exp_rd(a));
   endtask

   task automatic prd(input string tag, input logic [7:0] a);
      @(negedge clk);
      peer_we = 0; peer_addr = a;
      #1 chk(tag, peer_rdata, (slot_of(a) >= 0) ? m_st[slot_of(a)] : 32'd0);
   endtask

   task automatic chk_irq(input string tag);
      #0 chk(tag, {31'd0, irq}, {31'd0, |(m_pend & m_en0)});
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [7:0] addrs [14];
      int unsigned seed;
      addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C,
                8'h20, 8'h3C, 8'h40, 8'h50, 8'h6C, 8'h70};
      seed = $urandom(32'h5EED1);
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      // R1 reset values
      rd("R1 mask0", 8'h18); chk("R1 mask0 literal", host_rdata, 32'h82);
      rd("R1 busy", 8'h04); rd("R1 pending", 8'h10); rd("R1 scratch", 8'h24);
      chk("R1 irq", {31'd0, irq}, 32'd0);
      // R2 busy write-one-to-set
      cyc(1, 8'h04, 32'h01, 0, 0, 0, 0, 0, 0);
      cyc(1, 8'h04, 32'h04, 0, 0, 0, 0, 0, 0);
      rd("R2 busy accumulate", 8'h04); chk("R2 literal", host_rdata, 32'h05);
      // R3 doorbell and out-of-range channel
      cyc(1, 8'h0C, 32'd0, 0, 0, 0, 0, 0, 0);
      cyc(1, 8'h0C, 32'd9, 0, 0, 0, 0, 0, 0);
      rd("R3 send readback", 8'h0C);
      cyc(1, 8'h0C, 32'h100, 0, 0, 0, 0, 0, 0);
      rd("R3 send wrap readback", 8'h0C);
      cyc(1, 8'h0C, 32'd7, 0, 0, 0, 0, 0, 0);
      idle();
      // R4 take clears, set wins
      cyc(0, 0, 0, 0, 1, 3'd0, 0, 0, 0);
      rd("R4 take clears", 8'h04); chk("R4 literal", host_rdata, 32'h04);
      cyc(1, 8'h04, 32'h04, 0, 1, 3'd2, 0, 0, 0);
      rd("R4 set wins", 8'h04); chk("R4 set wins literal", host_rdata, 32'h04);
      // R5 / R8 events and interrupt
      cyc(0, 0, 0, 8'h02, 0, 0, 0, 0, 0);
      rd("R5 pending", 8'h10); chk_irq("R8 irq on enabled");
      cyc(0, 0, 0, 8'h10, 0, 0, 0, 0, 0);
      rd("R5 pending more", 8'h10);
      // R6 acknowledge
      cyc(1, 8'h14, 32'h02, 0, 0, 0, 0, 0, 0);
      rd("R6 ack clears", 8'h10); chk("R6 literal", host_rdata, 32'h10);
      chk_irq("R8 irq off after ack"); rd("R6 ack reads zero", 8'h14);
      // R7 event beats ack
      cyc(1, 8'h14, 32'h80, 8'h80, 0, 0, 0, 0, 0);
      rd("R7 event wins", 8'h10); chk("R7 literal", host_rdata, 32'h90);
      chk_irq("R8 irq exception");
      // R8 mask zero silences
      cyc(1, 8'h18, 32'h0, 0, 0, 0, 0, 0, 0);
      chk("R8 mask zero", {31'd0, irq}, 32'd0); rd("R8 pending kept", 8'h10);
      cyc(1, 8'h18, 32'h10, 0, 0, 0, 0, 0, 0);
      chk("R8 irq re-enabled", {31'd0, irq}, 32'd1);
      // R9 shared words
      cyc(1, 8'h20, 32'hCAFE0001, 0, 0, 0, 0, 0, 0);
      prd("R9 peer sees host", 8'h20);
      cyc(0, 0, 0, 0, 0, 0, 1, 8'h6C, 32'hBEEF0002);
      rd("R9 host sees peer", 8'h6C);
      cyc(1, 8'h50, 32'h11111111, 0, 0, 0, 1, 8'h50, 32'h22222222);
      rd("R9 host wins", 8'h50); chk("R9 literal", host_rdata, 32'h11111111);
      // R10 holes and plain storage
      cyc(1, 8'h40, 32'hFFFFFFFF, 0, 0, 0, 0, 0, 0);
      cyc(1, 8'h00, 32'hFFFFFFFF, 0, 0, 0, 1, 8'h70, 32'hFFFFFFFF);
      rd("R10 hole 0x40", 8'h40); rd("R10 hole 0x00", 8'h00);
      prd("R10 peer hole", 8'h70); rd("R10 no alias", 8'h3C);
      cyc(1, 8'h08, 32'h5A, 0, 0, 0, 0, 0, 0); rd("R10 start", 8'h08);
      cyc(1, 8'h1C, 32'hA5, 0, 0, 0, 0, 0, 0); rd("R10 mask1", 8'h1C);
      // random mix
      for (int it = 0; it < 400; it++) begin
         logic [7:0] ha, pa;
         logic [31:0] hd;
         ha = addrs[$urandom % 14];
         pa = addrs[$urandom % 14];
         hd = ($urandom % 3 == 0) ? ($urandom % 12) : $urandom;
         cyc($urandom % 2, ha, hd, 8'($urandom & $urandom & $urandom),
             ($urandom % 4) == 0, 3'($urandom), $urandom % 2, pa, $urandom);
         rd("R2 R5 R6 R9 R10 random read", addrs[$urandom % 14]);
         prd("R9 random peer read", addrs[$urandom % 14]);
         chk_irq("R8 random irq");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule